// File: doc/BRIEF.md
# Partial Product Reduction Pipeline

This block takes the thirteen partial product rows of a 24-bit by 24-bit radix-4 recoded significand multiply and turns them into one 48-bit product. The rows arrive packed side by side on one wide input with a valid flag. A first register bank captures them. The reduction tree then works through a fixed sequence of carry-save levels built from 3:2 counters: 13 rows become 9, then 6, 4, 3 and finally 2. One carry-propagate adder joins the last two rows, and a second register bank captures the result.

Each carry row moves one column to the left before it feeds the next level. Every row and every sum is kept modulo 2^48, so two's complement rows sign-extended to 48 bits add up to the exact product. When a level has two rows left over, they pass through a 3:2 counter whose third input is tied to zero.

The pipeline accepts a new set of rows on every clock. A valid flag travels with the data and marks each result. Recoding, normalization, exponent handling and rounding sit outside this block.

Top module: `pp_reduce_pipe`

## Requirements
- R1: While reset is asserted and until the first valid result, out_valid is 0 and out_prod is all zeros.
- R2: For each accepted set of rows, out_prod equals the sum of the 13 rows modulo 2^48. Row k occupies bits in_rows[48k+47:48k].
- R3: The rows presented with in_valid high at one rising edge produce out_valid high and their result at the second rising edge after it. An edge with in_valid low produces out_valid low two edges later.
- R4: A new set of rows is accepted on every clock with in_valid high. Back-to-back inputs give one result per clock, in input order, with none lost.
- R5: When in_valid is low, in_rows is ignored, and out_prod keeps its last result for as long as no new result arrives.
- R6: Suppose the rows are the 13 radix-4 recoded multiples of an unsigned 24-bit multiplicand a. Here multiplier b is extended to {2'b00, b, 1'b0}, and group k = bits [2k+2:2k] selects 0, +a, +2a, -2a or -a in the usual way. Each row is two's complement to 48 bits and shifted left by 2k. With such rows, out_prod equals the exact unsigned product a*b.
- R7: Row sums that pass 2^48 wrap around. Thirteen all-ones rows give 2^48-13, and thirteen rows holding only bit 47 give 2^47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_rows as a set of rows to reduce |
| in_rows | input | 624 | Thirteen 48-bit rows, row k at bits [48k+47:48k] |
| out_valid | output | 1 | Marks out_prod as a new result |
| out_prod | output | 48 | Sum of the rows modulo 2^48 |

## Verification
The hardest cases to reach are carries that travel through every level into the top columns and then fall off the end of the 48-bit range. Random operands seldom put enough weight there to cause a wrap. The stimulus forces these cases in three ways: rows that are all ones, rows that hold only the most significant bit, and recoded rows for extreme significands, whose negative multiples are sign-extended across the whole width. Long back-to-back streams with random gaps between them check that the valid flag and the data stay aligned through both register banks.

// File: rtl/wt_pkg.sv
package wt_pkg;

  localparam int PROD_W = 48;
  localparam int PP_ROWS = 13;

  // rows left after one level of 3:2 counters over n rows
  function automatic int next_rows(int n);
    return 2 * (n / 3) + n % 3;
  endfunction

  // number of levels needed to reach two rows
  function automatic int level_count(int n);
    int c;
    int r;
    c = 0;
    r = n;
    while (r > 2) begin
      r = next_rows(r);
      c++;
    end
    return c;
  endfunction

  // row count present at the input of level l
  function automatic int rows_at(int n0, int l);
    int r;
    r = n0;
    for (int k = 0; k < l; k++) r = next_rows(r);
    return r;
  endfunction

  // position (in rows) of level l inside the flat row pool
  function automatic int pool_offset(int n0, int l);
    int o;
    o = 0;
    for (int k = 0; k < l; k++) o += rows_at(n0, k);
    return o;
  endfunction

endpackage

// File: rtl/wt_counter32.sv
module wt_counter32 #(
  parameter int W = 48
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  assign s  = a ^ b ^ c;
  // carry moves one column up; the top carry leaves the modulo-2^W range
  assign cy = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]), 1'b0};

endmodule

// File: rtl/wt_csa_level.sv
module wt_csa_level #(
  parameter int W = 48,
  parameter int N_IN = 13,
  localparam int N_OUT = 2 * (N_IN / 3) + N_IN % 3
) (
  input  logic [N_IN*W-1:0]  rows_i,
  output logic [N_OUT*W-1:0] rows_o
);

  localparam int GROUPS = N_IN / 3;
  localparam int REST   = N_IN % 3;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    wt_counter32 #(.W(W)) u_cnt (
      .a (rows_i[(3*g)*W +: W]),
      .b (rows_i[(3*g+1)*W +: W]),
      .c (rows_i[(3*g+2)*W +: W]),
      .s (rows_o[(2*g)*W +: W]),
      .cy(rows_o[(2*g+1)*W +: W])
    );
  end

  if (REST == 2) begin : g_pair
    // two leftover rows: 3:2 counter with the third input held at zero
    wt_counter32 #(.W(W)) u_cnt (
      .a (rows_i[(3*GROUPS)*W +: W]),
      .b (rows_i[(3*GROUPS+1)*W +: W]),
      .c ({W{1'b0}}),
      .s (rows_o[(2*GROUPS)*W +: W]),
      .cy(rows_o[(2*GROUPS+1)*W +: W])
    );
  end else if (REST == 1) begin : g_pass
    assign rows_o[(2*GROUPS)*W +: W] = rows_i[(3*GROUPS)*W +: W];
  end

endmodule

// File: rtl/wt_tree.sv
module wt_tree #(
  parameter int W = 48,
  parameter int ROWS = 13
) (
  input  logic [ROWS*W-1:0] rows_i,
  output logic [W-1:0]      sum_o
);

  localparam int LEVELS = wt_pkg::level_count(ROWS);
  localparam int TOTAL  = wt_pkg::pool_offset(ROWS, LEVELS) + 2;
  localparam int FINAL  = wt_pkg::pool_offset(ROWS, LEVELS);

  // every level's rows live side by side in one flat pool
  wire [TOTAL*W-1:0] pool;

  assign pool[ROWS*W-1:0] = rows_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NI = wt_pkg::rows_at(ROWS, l);
    localparam int NO = wt_pkg::rows_at(ROWS, l + 1);
    localparam int OI = wt_pkg::pool_offset(ROWS, l);
    localparam int OO = wt_pkg::pool_offset(ROWS, l + 1);
    wt_csa_level #(.W(W), .N_IN(NI)) u_lvl (
      .rows_i(pool[OI*W +: NI*W]),
      .rows_o(pool[OO*W +: NO*W])
    );
  end

  // single carry-propagate addition of the two surviving rows
  assign sum_o = pool[FINAL*W +: W] + pool[(FINAL+1)*W +: W];

endmodule

// File: rtl/pp_reduce_pipe.sv
module pp_reduce_pipe #(
  parameter int W = wt_pkg::PROD_W,
  parameter int ROWS = wt_pkg::PP_ROWS,
  localparam int IN_W = ROWS * W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_rows,
  output logic            out_valid,
  output logic [W-1:0]    out_prod
);

  logic [IN_W-1:0] rows_q, rows_d;
  logic            v1_q, v1_d;
  logic [W-1:0]    tree_sum, prod_d;
  logic            v2_d;

  wt_tree #(.W(W), .ROWS(ROWS)) u_tree (
    .rows_i(rows_q),
    .sum_o (tree_sum)
  );

  // next-state logic with explicit clock enables
  always_comb begin
    v1_d   = in_valid;
    rows_d = in_valid ? in_rows : rows_q;
    v2_d   = v1_q;
    prod_d = v1_q ? tree_sum : out_prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q    <= '0;
      v1_q      <= 1'b0;
      out_prod  <= '0;
      out_valid <= 1'b0;
    end else begin
      rows_q    <= rows_d;
      v1_q      <= v1_d;
      out_prod  <= prod_d;
      out_valid <= v2_d;
    end
  end

  // plain ripple sum of the registered rows, used only by the checks
  function automatic logic [W-1:0] plain_total(logic [IN_W-1:0] v);
    logic [W-1:0] t;
    t = '0;
    for (int k = 0; k < ROWS; k++) t = t + v[k*W +: W];
    return t;
  endfunction

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
  AST_TREE_SUM: assert property (@(posedge clk) disable iff (!rst_n) v1_q |=> out_prod == $past(plain_total(rows_q))); // R2
  AST_LATENCY_HI: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ##1 out_valid); // R3
  AST_LATENCY_LO: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ##1 !out_valid); // R3
  AST_HOLD_PROD: assert property (@(posedge clk) disable iff (!rst_n) !v1_q |=> $stable(out_prod)); // R5

endmodule

// File: tb/pp_reduce_pipe_test.sv
module pp_reduce_pipe_test;

  localparam int W = 48;
  localparam int ROWS = 13;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [ROWS*W-1:0] in_rows;
  logic              out_valid;
  logic [W-1:0]      out_prod;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int sent = 0;
  int got = 0;
  logic [W-1:0] last_exp;

  logic [W-1:0] exp_q[$];
  int           stamp_q[$];
  string        tag_q[$];

  pp_reduce_pipe #(.W(W), .ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rows(in_rows),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  function automatic logic [W-1:0] rand48();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_sum(logic [ROWS*W-1:0] r);
    logic [W-1:0] t;
    t = '0;
    for (int k = 0; k < ROWS; k++) t = t + r[k*W +: W];
    return t;
  endfunction

  function automatic logic [ROWS*W-1:0] booth_rows(logic [23:0] a, logic [23:0] b);
    logic [26:0]       ext;
    logic [ROWS*W-1:0] r;
    longint            d;
    longint            p;
    logic [W-1:0]      m;
    ext = {2'b00, b, 1'b0};
    for (int k = 0; k < ROWS; k++) begin
      case (ext[2*k +: 3])
        3'b001, 3'b010: d = 1;
        3'b011:         d = 2;
        3'b100:         d = -2;
        3'b101, 3'b110: d = -1;
        default:        d = 0;
      endcase
      p = d * longint'(a);
      m = p[W-1:0];
      r[k*W +: W] = m << (2 * k);
    end
    return r;
  endfunction

  task automatic send(logic [ROWS*W-1:0] rows, logic [W-1:0] exp, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_rows  = rows;
    exp_q.push_back(exp);
    stamp_q.push_back(cyc);
    tag_q.push_back(tag);
    last_exp = exp;
    sent++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < ROWS; k++) in_rows[k*W +: W] = rand48();
    end
  endtask

  task automatic send_booth(logic [23:0] a, logic [23:0] b, string tag);
    send(booth_rows(a, b), {24'b0, a} * {24'b0, b}, tag);
  endtask

  // monitor: pops expected results as the design produces them
  always @(posedge clk) begin
    #1;
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "result with nothing pending", out_prod, '0);
      end else begin
        logic [W-1:0] e;
        int           st;
        string        tg;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        tg = tag_q.pop_front();
        got++;
        check(out_prod === e, tg, "product", out_prod, e);
        check(cyc == st + 2, "R3", "latency in cycles", W'(cyc - st), W'(2));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", '0, '0);
    summary();
    $finish;
  end

  initial begin
    logic [ROWS*W-1:0] r;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_rows  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", W'(out_valid), '0);
    check(out_prod === '0, "R1", "out_prod in reset", out_prod, '0);
    rst_n = 1'b1;
    idle(3);
    check(out_valid === 1'b0, "R1", "out_valid after reset", W'(out_valid), '0);
    check(out_prod === '0, "R1", "out_prod after reset", out_prod, '0);

    // R6 boundary significands
    send_booth(24'h800000, 24'h800000, "R6");
    send_booth(24'hFFFFFF, 24'hFFFFFF, "R6");
    send_booth(24'h800000, 24'hFFFFFF, "R6");
    send_booth(24'hFFFFFF, 24'h800000, "R6");
    send_booth(24'hAAAAAA, 24'h555555, "R6");
    send_booth(24'h000000, 24'hFFFFFF, "R6");
    send_booth(24'hC00001, 24'hBFFFFF, "R6");
    idle(2);

    // R7 wraparound
    send({ROWS{ {W{1'b1}} }}, 48'hFFFF_FFFF_FFF3, "R7");
    send({ROWS{ 1'b1, {(W-1){1'b0}} }}, 48'h8000_0000_0000, "R7");
    idle(1);

    // R4 back-to-back recoded operand stream
    for (int i = 0; i < 150; i++)
      send_booth(24'h800000 | 24'($urandom()), 24'h800000 | 24'($urandom()), "R4");

    // R2 arbitrary rows with random gaps
    for (int i = 0; i < 150; i++) begin
      for (int k = 0; k < ROWS; k++) r[k*W +: W] = rand48();
      send(r, ref_sum(r), "R2");
      if ($urandom_range(3) == 0) idle($urandom_range(3) + 1);
    end

    // R6 random operands without forced leading one
    for (int i = 0; i < 60; i++)
      send_booth(24'($urandom()), 24'($urandom()), "R6");

    idle(4);
    check(got == sent, "R4", "results count", W'(got), W'(sent));

    // R5 garbage rows with in_valid low must not disturb the output
    for (int i = 0; i < 6; i++) begin
      idle(1);
      check(out_prod === last_exp, "R5", "held product", out_prod, last_exp);
      check(out_valid === 1'b0, "R5", "no valid while idle", W'(out_valid), '0);
    end

    summary();
    $finish;
  end

endmodule